// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block serialises characters onto a single transmit line. A character of eight or nine bits is written into a one-deep holding register. When the shifter is free, the character moves into it and goes out as a frame: a low start bit, then the data bits least significant first, then a high stop bit. A ninth data bit is placed between bit 7 and the stop bit only when the nine-bit control is high. Bit timing comes from a single-cycle `baud_tick` pulse supplied from outside, and every bit on the line lasts exactly one tick period.

A level-sensitive break request makes the transmitter send break frames instead of data. A break frame is as long as a data frame for the current character size, and the line is held low for its whole length. Break frames follow one another with no gap for as long as the request stays high. When the request drops, the break frame already on the line completes, and then the line is driven high for exactly one bit time. This guaranteed mark lets a receiver find the next start bit. Data written during a break waits in the holding register and is sent after that mark.

The block has four named states:
- `TX_IDLE`: the line is high.
- `TX_FRAME`: a data frame is shifting out.
- `TX_BREAK`: a break frame is shifting out.
- `TX_MARK`: the one forced high bit after a break.

State changes happen only on a baud tick. The transitions are:
- **idle-to-break**, **mark-to-break**, **frame-to-break**: taken when a break is requested.
- **idle-to-frame**, **mark-to-frame**, **frame-to-frame**: taken when data is pending and no break is requested.
- **break-to-break**: the request is still high at the end of a break frame.
- **break-to-mark**: the request has dropped at the end of a break frame.
- **frame-to-idle**, **mark-to-idle**: taken when nothing is pending.

A break request has priority over pending data.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1 and `tx_done` is 1.
- R2: With `char9`=0, a frame is 10 bit times: one start bit of 0, `wr_data[0]` through `wr_data[7]` in that order, and one stop bit of 1. Each bit lasts one `baud_tick` period, and `txd` changes only in the cycle after a tick.
- R3: With `char9`=1, a frame is 11 bit times, and `wr_data[8]` is sent between `wr_data[7]` and the stop bit.
- R4: A write (`wr_en`=1) clears `tx_empty` in the next cycle. `tx_empty` returns to 1 when the held character moves into the shifter, which happens at the tick that begins its start bit.
- R5: `tx_done` is 1 only when the transmitter is in `TX_IDLE`, `tx_empty` is 1 and `brk_req` is 0. It is 0 while a frame or a break is being sent.
- R6: While `brk_req` is 1, `txd` stays 0 in whole break frames of 10 bit times (`char9`=0) or 11 bit times (`char9`=1), placed back to back with no gap.
- R7: After `brk_req` falls, the break frame in progress completes. Then `txd` is 1 for exactly one bit time before any further start bit.
- R8: A break request takes priority over pending data. A character written during a break stays held, with `tx_empty` at 0, and is sent unchanged after the mark bit that follows the break.
- R9: A character written while a frame is being sent has its start bit right after the previous stop bit, with no idle time between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| char9 | input | 1 | Character size: 1 selects nine data bits, 0 selects eight |
| brk_req | input | 1 | Level-sensitive request to send break frames |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send; bit 8 is used only when `char9` is 1 |
| txd | output | 1 | Serial transmit line; idles high |
| tx_empty | output | 1 | Holding register is free to accept a character |
| tx_done | output | 1 | Line is idle and nothing is pending or requested |

## Verification
Eight-bit frames are driven with alternating, all-ones and single-one data. This separates bit order from stuck or shifted data. Nine-bit frames are sent once with bit 8 set and once with it cleared, which shows that the extra bit occupies its own slot rather than overlapping the stop bit. A character written while another is being sent checks the load at the frame boundary and the absence of any gap. Break runs in both character sizes are released in the middle of a later break frame. The measured low length then shows whole frames with no gaps, and the high run that follows shows the single mark bit. In one of these runs a character is written during the break, so the high run must end in that character's start bit.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_FRAME = 2'd1,
        TX_BREAK = 2'd2,
        TX_MARK  = 2'd3
    } txb_state_e;
endpackage

// File: rtl/txb_holding.sv
module txb_holding #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] hold_q,
    output logic          empty_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_en) begin
                hold_q  <= wr_data;
                empty_q <= 1'b0;
            end else if (take) begin
                empty_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txb_bitcnt.sv
module txb_bitcnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_txb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic        char9,
    input  logic        brk_req,
    input  logic        wr_en,
    input  logic [DW:0] wr_data,
    output logic        txd,
    output logic        tx_empty,
    output logic        tx_done
);
    localparam int FRAME_MAX = DW + 3;
    localparam int CW        = $clog2(FRAME_MAX);
    localparam logic [CW-1:0] LEN_LONG  = CW'(FRAME_MAX - 1);
    localparam logic [CW-1:0] LEN_SHORT = CW'(FRAME_MAX - 2);

    txb_state_e state_q, state_d;
    logic [FRAME_MAX-1:0] shift_q;
    logic [DW:0]          hold_q;
    logic                 bit_last;
    logic                 boundary;
    logic                 ld_frame, ld_break;
    txb_state_e           pick;

    txb_holding #(.DW(DW + 1)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (ld_frame),
        .hold_q  (hold_q),
        .empty_q (tx_empty)
    );

    txb_bitcnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_frame || ld_break),
        .load_val (char9 ? LEN_LONG : LEN_SHORT),
        .tick     (baud_tick),
        .last     (bit_last)
    );

    // next-state selection, evaluated only at bit boundaries
    always_comb begin
        pick     = brk_req ? TX_BREAK : (!tx_empty ? TX_FRAME : TX_IDLE);
        state_d  = state_q;
        boundary = 1'b0;
        if (baud_tick) begin
            unique case (state_q)
                TX_IDLE: begin
                    boundary = 1'b1;
                    state_d  = pick;
                end
                TX_FRAME: begin
                    boundary = bit_last;
                    if (bit_last) state_d = pick;
                end
                TX_BREAK: begin
                    boundary = bit_last;
                    if (bit_last) state_d = brk_req ? TX_BREAK : TX_MARK;
                end
                TX_MARK: begin
                    boundary = 1'b1;
                    state_d  = pick;
                end
            endcase
        end
        ld_frame = boundary && (state_d == TX_FRAME);
        ld_break = boundary && (state_d == TX_BREAK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else if (ld_frame) begin
            shift_q <= {1'b1, (char9 ? hold_q[DW] : 1'b1), hold_q[DW-1:0], 1'b0};
        end else if (ld_break) begin
            shift_q <= '0;
        end else if (baud_tick) begin
            shift_q <= {1'b1, shift_q[FRAME_MAX-1:1]};
        end
    end

    always_comb begin
        unique case (state_q)
            TX_FRAME, TX_BREAK: txd = shift_q[0];
            TX_IDLE, TX_MARK:   txd = 1'b1;
        endcase
        tx_done = (state_q == TX_IDLE) && tx_empty && !brk_req;
    end
endmodule

// File: rtl/uart_txb_chk.sv
module uart_txb_chk
    import uart_txb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       brk_req,
    input logic       wr_en,
    input logic       txd,
    input logic       tx_empty,
    input logic       tx_done,
    input txb_state_e state_q,
    input logic       bit_last
);
    p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    p_write_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    p_done_only_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (tx_empty && !brk_req && txd));

    p_break_line_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_BREAK) |-> !txd);

    p_mark_after_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_BREAK && baud_tick && bit_last && !brk_req) |=> (state_q == TX_MARK && txd));

    p_break_before_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_BREAK && baud_tick && brk_req && (state_q != TX_FRAME || bit_last))
        |=> (state_q == TX_BREAK));
endmodule

bind uart_tx_brk uart_txb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .brk_req   (brk_req),
    .wr_en     (wr_en),
    .txd       (txd),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .state_q   (state_q),
    .bit_last  (bit_last)
);

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NVEC       = 6;
    // {char9, data[8:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        10'h0A5, 10'h0FF, 10'h001, 10'h3C3, 10'h23C, 10'h300
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       char9 = 1'b0;
    logic       brk_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, tx_empty, tx_done;
    logic [1:0] tcnt = '0;
    int         n_chk = 0;
    int         n_fail = 0;

    uart_tx_brk u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char9(char9),
        .brk_req(brk_req), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt      <= '0;
            baud_tick <= 1'b0;
        end else begin
            tcnt      <= tcnt + 1'b1;
            baud_tick <= (tcnt == 2'(TICK_DIV - 1));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wait_low(input string req);
        int guard = 0;
        while (txd && guard < 2000) begin
            step(1);
            guard++;
        end
        if (guard >= 2000) chk(0, req, 1, 0);
    endtask

    task automatic write_char(input logic [8:0] d, input string req);
        wr_data = d;
        wr_en   = 1'b1;
        step(1);
        wr_en   = 1'b0;
        chk(tx_empty == 1'b0, req, int'(tx_empty), 0);
    endtask

    // mode 0: find the start bit; 1: already mid start bit; 2: mid previous bit
    task automatic frame_check(input logic m, input logic [8:0] d, input int mode, input string req);
        int nb = m ? 11 : 10;
        if (mode == 0) begin
            wait_low(req);
            step(TICK_DIV/2);
        end else if (mode == 2) begin
            step(TICK_DIV);
        end
        for (int i = 0; i < nb; i++) begin
            logic e;
            if (i == 0)               e = 1'b0;
            else if (i <= 8)          e = d[i-1];
            else if (m && i == 9)     e = d[8];
            else                      e = 1'b1;
            chk(txd == e, req, int'(txd), int'(e));
            if (i < nb - 1) step(TICK_DIV);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int k;
        int h;
        // R1: reset values
        step(3);
        chk(txd == 1'b1, "R1", int'(txd), 1);
        chk(tx_empty == 1'b1, "R1", int'(tx_empty), 1);
        chk(tx_done == 1'b1, "R1", int'(tx_done), 1);
        rst_n = 1'b1;
        step(6);
        chk(txd == 1'b1, "R1", int'(txd), 1);

        // table walk: R2 (8-bit), R3 (9-bit), R4 / R5 around each frame
        for (int v = 0; v < NVEC; v++) begin
            char9 = VEC[v][9];
            write_char(VEC[v][8:0], "R4");
            chk(tx_done == 1'b0, "R5", int'(tx_done), 0);
            frame_check(VEC[v][9], VEC[v][8:0], 0, VEC[v][9] ? "R3" : "R2");
            step(8);
            chk(tx_done == 1'b1, "R5", int'(tx_done), 1);
        end

        // R9: back-to-back, and R4 flag set at transfer
        char9 = 1'b0;
        write_char(9'h05A, "R4");
        wait_low("R9");
        chk(tx_empty == 1'b1, "R4", int'(tx_empty), 1);
        write_char(9'h096, "R4");
        step(1);
        frame_check(1'b0, 9'h05A, 1, "R9");
        frame_check(1'b0, 9'h096, 2, "R9");
        step(10);

        // R6/R7/R8: 8-bit break with data written during break
        brk_req = 1'b1;
        step(1);
        chk(tx_done == 1'b0, "R5", int'(tx_done), 0);
        wait_low("R6");
        write_char(9'h033, "R8");
        step(98);
        brk_req = 1'b0;
        k = 0;
        while (!txd && k < 500) begin step(1); k++; end
        chk(99 + k == 120, "R6", 99 + k, 120);
        chk(tx_empty == 1'b0, "R8", int'(tx_empty), 0);
        h = 0;
        while (txd && h < 500) begin step(1); h++; end
        chk(h == TICK_DIV, "R7", h, TICK_DIV);
        step(TICK_DIV/2);
        frame_check(1'b0, 9'h033, 1, "R8");
        step(10);

        // R6/R7: 9-bit break, no data pending
        char9 = 1'b1;
        brk_req = 1'b1;
        wait_low("R6");
        step(50);
        chk(tx_done == 1'b0, "R5", int'(tx_done), 0);
        brk_req = 1'b0;
        k = 0;
        while (!txd && k < 500) begin step(1); k++; end
        chk(50 + k == 88, "R6", 50 + k, 88);
        step(TICK_DIV);
        chk(txd == 1'b1, "R7", int'(txd), 1);
        step(8);
        chk(tx_done == 1'b1, "R5", int'(tx_done), 1);
        chk(txd == 1'b1, "R7", int'(txd), 1);

        summary();
    end
endmodule